// File: doc/BRIEF.md
# Vector FP Exception Flag Accumulator

This block sits beside the lanes of a vector floating-point datapath. It takes the exception flags that each lane produces and folds them into the sticky architectural flag register. A lane contributes only when it is active, which means three things hold: its element index is at or above the start index, it is below the vector length, and it is unmasked. When the vm bit is set, the mask register is ignored. The active-lane gating is applied inside the OR-reduction of the lane flags, so an inactive lane can never set a flag.

Whenever a vector FP instruction issues, the block checks the dynamic rounding mode. A reserved mode raises an illegal-instruction pulse. This check runs whatever the instruction and whatever the vector length, including zero. A legal mode is latched and passed to the lanes. The block gathers flags group by group while the instruction runs. It writes them into the architectural register only when the last element group arrives, and it writes nothing for an illegal instruction.

Top module: `vfx_flag_accum`

## Requirements
- R1: After reset, `fflags_o` is 0, `illegal_o` is 0 and `lane_rm_o` is 0.
- R2: An issue with `frm_i` of 5, 6 or 7 drives `illegal_o` high for exactly the next cycle. An issue with `frm_i` from 0 to 4 leaves `illegal_o` low.
- R3: An issue with a legal `frm_i` places that value on `lane_rm_o` from the next cycle, and it stays there until the next legal issue.
- R4: After an illegal issue, the element groups that follow change no flag in `fflags_o`.
- R5: With `vm_i`=0, a lane whose element has a mask bit of 0 contributes no flag. Element e uses `mask_i[e]`, and element e is lane `e % LANES` of group `e / LANES`.
- R6: A lane whose element index is at or above the latched vector length contributes no flag.
- R7: A lane whose element index is below the latched start index contributes no flag.
- R8: With `vm_i`=1, every element in the range [start, vl) contributes, whatever the mask bits are.
- R9: Flags are sticky. The committed value is the old `fflags_o` OR-ed with the gated flags of all groups of the instruction. The bit order, from MSB to LSB, is invalid (bit 4), divide-by-zero (bit 3), overflow (bit 2), underflow (bit 1) and inexact (bit 0).
- R10: `fflags_o` does not change until the cycle after the group marked last is accepted. In that cycle it includes the flags of every group of the instruction.
- R11: When the vector length is 0, the rounding-mode check still runs and a reserved mode still raises `illegal_o`. A legal zero-length instruction commits no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| issue_i | input | 1 | A vector FP instruction issues; the configuration inputs are sampled in this cycle |
| frm_i | input | 3 | Dynamic rounding-mode register value |
| vl_i | input | $clog2(VLMAX+1) | Vector length |
| vstart_i | input | $clog2(VLMAX+1) | First element index |
| vm_i | input | 1 | 1 = unmasked instruction |
| mask_i | input | VLMAX | Mask register bits, one per element |
| grp_valid_i | input | 1 | An element group's lane flags are present |
| grp_idx_i | input | max(1,$clog2(VLMAX/LANES)) | Index of the element group |
| grp_last_i | input | 1 | This is the instruction's final group |
| lane_flags_i | input | LANES*5 | Per-lane flags; lane l occupies bits [5l+4:5l] |
| fflags_o | output | 5 | Sticky architectural exception flags |
| illegal_o | output | 1 | Illegal-instruction pulse for a reserved rounding mode |
| lane_rm_o | output | 3 | Rounding mode driven to the lanes |

## Verification
`illegal_o` and `lane_rm_o` are due one clock edge after the issue cycle. `fflags_o` is due one edge after the group marked last is accepted. The bench drives inputs on falling edges and samples each result at the falling edge that follows the rising edge where it is due. For groups before the last one, it checks at that same point that `fflags_o` still holds its previous value. Each lane's flag is a distinct bit that depends on the element index, so a lane that is gated wrongly changes the expected OR. The expected OR comes from the start index, the vector length, the vm bit and the mask, applied element by element.

// File: rtl/vfx_flag_pkg.sv
package vfx_flag_pkg;
  localparam int FLAG_W = 5;

  typedef struct packed {
    logic nv;
    logic dz;
    logic of;
    logic uf;
    logic nx;
  } fp_flags_t;

  typedef logic [2:0] rm_t;
  localparam rm_t RM_LAST_LEGAL = 3'd4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } accum_state_t;
endpackage

// File: rtl/vfx_rm_check.sv
module vfx_rm_check
  import vfx_flag_pkg::*;
(
  input  rm_t  frm_i,
  output logic legal_o
);
  always_comb begin
    legal_o = (frm_i <= RM_LAST_LEGAL);
  end
endmodule

// File: rtl/vfx_lane_active.sv
module vfx_lane_active #(
  parameter int LANES = 4,
  parameter int VLMAX = 16
) (
  input  logic                 clk,
  input  logic                 rst_sync_n,
  input  logic [GW-1:0]        grp_idx_i,
  input  logic [VLW-1:0]       vl_i,
  input  logic [VLW-1:0]       vstart_i,
  input  logic                 vm_i,
  input  logic [VLMAX-1:0]     mask_i,
  output logic [LANES-1:0]     active_o
);
  localparam int VLW    = $clog2(VLMAX + 1);
  localparam int GROUPS = VLMAX / LANES;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic [VLW:0]       base;
  logic [LANES-1:0]   grp_mask;

  always_comb begin
    base     = (VLW + 1)'(grp_idx_i) * (VLW + 1)'(LANES);
    grp_mask = mask_i[grp_idx_i * LANES +: LANES];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [VLW:0] elem;
    always_comb begin
      elem        = base + (VLW + 1)'(l);
      active_o[l] = (elem >= {1'b0, vstart_i}) &&
                    (elem <  {1'b0, vl_i}) &&
                    (vm_i || grp_mask[l]);
    end
  end

  // No lane of a group wholly at or beyond the length may be active (R6)
  assert_tail_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (base >= {1'b0, vl_i}) |-> (active_o == '0));

  // No lane of a group wholly below the start index may be active (R7)
  assert_prestart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((base + (VLW + 1)'(LANES)) <= {1'b0, vstart_i}) |-> (active_o == '0));
endmodule

// File: rtl/vfx_flag_reduce.sv
module vfx_flag_reduce
  import vfx_flag_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*FLAG_W-1:0] lane_flags_i,
  input  logic [LANES-1:0]        active_i,
  output fp_flags_t               or_flags_o
);
  logic [FLAG_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int l = 0; l < LANES; l++) begin
      acc = acc | (lane_flags_i[l*FLAG_W +: FLAG_W] & {FLAG_W{active_i[l]}});
    end
    or_flags_o = fp_flags_t'(acc);
  end
endmodule

// File: rtl/vfx_flag_accum.sv
module vfx_flag_accum
  import vfx_flag_pkg::*;
#(
  parameter int LANES = 4,
  parameter int VLMAX = 16,
  localparam int VLW    = $clog2(VLMAX + 1),
  localparam int GROUPS = VLMAX / LANES,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_i,
  input  logic [2:0]              frm_i,
  input  logic [VLW-1:0]          vl_i,
  input  logic [VLW-1:0]          vstart_i,
  input  logic                    vm_i,
  input  logic [VLMAX-1:0]        mask_i,
  input  logic                    grp_valid_i,
  input  logic [GW-1:0]           grp_idx_i,
  input  logic                    grp_last_i,
  input  logic [LANES*FLAG_W-1:0] lane_flags_i,
  output logic [FLAG_W-1:0]       fflags_o,
  output logic                    illegal_o,
  output logic [2:0]              lane_rm_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  accum_state_t      state_q, state_d;
  logic [VLW-1:0]    vl_q, vstart_q;
  logic              vm_q;
  logic [VLMAX-1:0]  mask_q;
  rm_t               rm_q, rm_d;
  logic              illegal_q, illegal_d;
  logic [FLAG_W-1:0] pend_q, pend_d;
  logic [FLAG_W-1:0] ff_q, ff_d;

  logic              rm_legal;
  logic              cfg_en;
  logic              grp_take;
  logic [LANES-1:0]  lane_active;
  fp_flags_t         grp_or;

  vfx_rm_check u_rm_check (
    .frm_i   (frm_i),
    .legal_o (rm_legal)
  );

  vfx_lane_active #(.LANES(LANES), .VLMAX(VLMAX)) u_lane_active (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .grp_idx_i  (grp_idx_i),
    .vl_i       (vl_q),
    .vstart_i   (vstart_q),
    .vm_i       (vm_q),
    .mask_i     (mask_q),
    .active_o   (lane_active)
  );

  vfx_flag_reduce #(.LANES(LANES)) u_flag_reduce (
    .lane_flags_i (lane_flags_i),
    .active_i     (lane_active),
    .or_flags_o   (grp_or)
  );

  always_comb begin
    cfg_en    = issue_i && rm_legal;
    grp_take  = !issue_i && (state_q == ST_RUN) && grp_valid_i;
    state_d   = state_q;
    rm_d      = rm_q;
    pend_d    = pend_q;
    ff_d      = ff_q;
    illegal_d = issue_i && !rm_legal;
    if (issue_i) begin
      pend_d = '0;
      if (rm_legal) begin
        state_d = ST_RUN;
        rm_d    = frm_i;
      end else begin
        state_d = ST_IDLE;
      end
    end else if (grp_take) begin
      if (grp_last_i) begin
        ff_d    = ff_q | pend_q | grp_or;
        pend_d  = '0;
        state_d = ST_IDLE;
      end else begin
        pend_d = pend_q | grp_or;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_IDLE;
      rm_q      <= '0;
      pend_q    <= '0;
      ff_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rm_q      <= rm_d;
      pend_q    <= pend_d;
      ff_q      <= ff_d;
      illegal_q <= illegal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vl_q     <= '0;
      vstart_q <= '0;
      vm_q     <= 1'b0;
      mask_q   <= '0;
    end else if (cfg_en) begin
      vl_q     <= vl_i;
      vstart_q <= vstart_i;
      vm_q     <= vm_i;
      mask_q   <= mask_i;
    end
  end

  assign fflags_o  = ff_q;
  assign illegal_o = illegal_q;
  assign lane_rm_o = rm_q;

  assert_reserved_rm_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_i && (frm_i > 3'd4)) |=> illegal_o);

  assert_rm_forward_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_i && (frm_i <= 3'd4)) |=> ((lane_rm_o == $past(frm_i)) && !illegal_o));

  assert_illegal_idle_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal_o |-> (state_q == ST_IDLE));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((fflags_o & $past(fflags_o)) == $past(fflags_o)));

  assert_hold_until_last_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(grp_take && grp_last_i) |=> $stable(fflags_o));
endmodule

// File: tb/vfx_flag_accum_test.sv
module vfx_flag_accum_test;
  localparam int LANES  = 4;
  localparam int VLMAX  = 16;
  localparam int VLW    = $clog2(VLMAX + 1);
  localparam int GROUPS = VLMAX / LANES;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  issue_i;
  logic [2:0]            frm_i;
  logic [VLW-1:0]        vl_i, vstart_i;
  logic                  vm_i;
  logic [VLMAX-1:0]      mask_i;
  logic                  grp_valid_i;
  logic [GW-1:0]         grp_idx_i;
  logic                  grp_last_i;
  logic [LANES*5-1:0]    lane_flags_i;
  logic [4:0]            fflags_o;
  logic                  illegal_o;
  logic [2:0]            lane_rm_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [4:0] model_ff;
  logic [2:0] model_rm;

  always #2.5 clk = ~clk;

  vfx_flag_accum #(.LANES(LANES), .VLMAX(VLMAX)) uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .frm_i(frm_i),
    .vl_i(vl_i), .vstart_i(vstart_i), .vm_i(vm_i), .mask_i(mask_i),
    .grp_valid_i(grp_valid_i), .grp_idx_i(grp_idx_i), .grp_last_i(grp_last_i),
    .lane_flags_i(lane_flags_i), .fflags_o(fflags_o), .illegal_o(illegal_o),
    .lane_rm_o(lane_rm_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] elem_flag(input int e, input int seed);
    return 5'(1 << ((e + seed) % 5));
  endfunction

  function automatic logic [4:0] exp_or(input int vl, input int vs, input logic vm,
                                        input logic [VLMAX-1:0] m, input int seed);
    logic [4:0] acc = '0;
    for (int e = 0; e < VLMAX; e++)
      if (e >= vs && e < vl && (vm || m[e])) acc |= elem_flag(e, seed);
    return acc;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    issue_i = 1'b0; grp_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_ff = '0;
    model_rm = '0;
  endtask

  task automatic run_instr(input logic [2:0] frm, input int vl, input int vs,
                           input logic vm, input logic [VLMAX-1:0] m, input int seed,
                           input string tag);
    logic legal = (frm <= 3'd4);
    issue_i = 1'b1; frm_i = frm; vl_i = VLW'(vl); vstart_i = VLW'(vs);
    vm_i = vm; mask_i = m;
    @(negedge clk);
    issue_i = 1'b0;
    chk("R2 illegal pulse", 32'(illegal_o), 32'(!legal));
    if (legal) model_rm = frm;
    chk("R3 lane rounding mode", 32'(lane_rm_o), 32'(model_rm));
    for (int g = 0; g < GROUPS; g++) begin
      grp_valid_i = 1'b1;
      grp_idx_i   = GW'(g);
      grp_last_i  = (g == GROUPS - 1);
      for (int l = 0; l < LANES; l++)
        lane_flags_i[l*5 +: 5] = elem_flag(g * LANES + l, seed);
      @(negedge clk);
      if (g != GROUPS - 1) chk("R10 no early commit", 32'(fflags_o), 32'(model_ff));
      if (g == 0) chk("R2 illegal single cycle", 32'(illegal_o), 32'(0));
    end
    grp_valid_i = 1'b0;
    grp_last_i  = 1'b0;
    if (legal) model_ff = model_ff | exp_or(vl, vs, vm, m, seed);
    chk(tag, 32'(fflags_o), 32'(model_ff));
  endtask

  initial begin
    rst_n = 1'b0;
    issue_i = 1'b0; frm_i = '0; vl_i = '0; vstart_i = '0; vm_i = 1'b0;
    mask_i = '0; grp_valid_i = 1'b0; grp_idx_i = '0; grp_last_i = 1'b0;
    lane_flags_i = '0;
    do_reset();
    chk("R1 reset fflags", 32'(fflags_o), 32'(0));
    chk("R1 reset illegal", 32'(illegal_o), 32'(0));
    chk("R1 reset rounding mode", 32'(lane_rm_o), 32'(0));

    // R2 R3: every rounding-mode encoding
    for (int f = 0; f < 8; f++) run_instr(3'(f), 16, 0, 1'b1, '1, f, "R3 R9 rm sweep commit");

    // R4 and R11: illegal instructions commit nothing, including zero length
    do_reset();
    run_instr(3'd6, 16, 0, 1'b1, '1, 1, "R4 illegal no commit");
    run_instr(3'd7, 0, 0, 1'b1, '1, 2, "R11 zero length illegal");
    run_instr(3'd5, 0, 0, 1'b0, '0, 3, "R11 zero length illegal masked");
    run_instr(3'd1, 0, 0, 1'b1, '1, 4, "R11 zero length legal no flags");

    // R5 R6 R7 R8: sweep of length, start, vm and mask with fresh flags each time
    for (int vi = 0; vi < 7; vi++) begin
      for (int si = 0; si < 3; si++) begin
        for (int vmi = 0; vmi < 2; vmi++) begin
          for (int mi = 0; mi < 3; mi++) begin
            int vls[7] = '{0, 1, 3, 4, 5, 9, 16};
            int vss[3] = '{0, 2, 7};
            logic [VLMAX-1:0] ms[3] = '{16'hA5C3, 16'h0000, 16'hFFFF};
            do_reset();
            run_instr(3'(vi % 5), vls[vi], vss[si], 1'(vmi), ms[mi], vi + si + mi,
                      "R5 R6 R7 R8 gated commit");
          end
        end
      end
    end

    // R9: sticky accumulation over several instructions without reset
    do_reset();
    run_instr(3'd0, 3, 0, 1'b1, '1, 0, "R9 sticky first");
    run_instr(3'd2, 8, 5, 1'b0, 16'h00F0, 1, "R9 sticky second");
    run_instr(3'd3, 16, 12, 1'b1, '0, 2, "R9 sticky third");
    run_instr(3'd7, 16, 0, 1'b1, '1, 3, "R4 R9 sticky after illegal");

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule